// File: doc/BRIEF.md
# Cell-Based Source Session Transmitter

This block sits between a producer that delivers 8-bit words at its own pace and one port of a circuit-switched on-chip network. It collects the producer's words into a cell buffer. A cell is closed when it reaches the configured cell length, or earlier when the producer marks the end of a message. Once a cell is closed, the block sends a two-flit control packet that asks the network for a path to the target. It then waits for the target's answer.

An acknowledge means the path and the session are in place. The block then sends the stored cell in one burst at link rate, with no idle cycles, and flags its final flit on an end-of-packet sideband that releases the path. A non-acknowledge means the target is busy. The block goes quiet for one cell time and then repeats the same control packet.

Each control packet tells the target whether its cell opens a message, continues one, or closes it, so the target can open and close a session around the message. While a cell waits for its path or is being sent, the producer is stalled.

Top module: `cell_session_tx`

## Requirements
- R1: After reset, `out_valid` and `out_eop` are low and `in_ready` is high.
- R2: `in_ready` stays high while a cell is filling. It is low in the cycle after a word is accepted that either completes `CELL_FLITS` words or carries `in_last`. It stays low until the last flit of that cell has been sent.
- R3: The first control flit appears one clock edge after the cell-closing word is accepted, and the second follows on the next edge. Both have `out_valid` high and `out_eop` low. Flit 0 is {zero pad, position[1:0] in bits 6:5, target address in bits 4:0}. Flit 1 is {zero pad, source address in bits 4:0}. In the 5-bit addresses, bits 3:0 name a router and bit 4 names the local port at that router.
- R4: The position code is 2'b01 for the first cell of a multi-cell message, 2'b10 for a middle cell, and 2'b11 for the last cell or the only cell.
- R5: After the control packet, `out_valid` stays low until an acknowledge is sampled.
- R6: When `ack` is sampled at a clock edge, data flit 0 appears on the next edge. The remaining flits of the cell follow in write order, one per cycle, with no gaps.
- R7: `out_eop` is high only together with `out_valid`, and only on the final flit of a cell. The cycle after it, `out_valid` is low.
- R8: A closing cell that is shorter than `CELL_FLITS` is sent with exactly the number of words written into it.
- R9: When `nack` is sampled instead of `ack`, the link stays idle. The identical control packet then starts `CELL_FLITS`+1 edges after the edge that sampled `nack`. This repeats for every non-acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | FLIT_W | Producer word |
| in_valid | input | 1 | Producer word is valid |
| in_last | input | 1 | Word is the final word of a message |
| in_ready | output | 1 | Block accepts a producer word this cycle |
| dst_addr | input | ADDR_W | Target address, captured when the cell closes |
| src_addr | input | ADDR_W | Own address, captured when the cell closes |
| ack | input | 1 | Path and session granted by the target |
| nack | input | 1 | Target busy, retry later |
| out_flit | output | FLIT_W | Flit toward the network |
| out_valid | output | 1 | `out_flit` carries a flit |
| out_eop | output | 1 | Final flit of a cell, path release |

## Verification
Every timed result is tied to a clock edge the bench can count. The first control flit is due one edge after the cell-closing word. The first data flit is due one edge after `ack` is sampled, and the last data flit `len` edges after it. A repeated control packet is due `CELL_FLITS`+1 edges after `nack` is sampled. The bench keeps a running edge counter and samples on the falling edge. The monitor stamps each flit it pops from the expected queue, and the driver compares those stamps with the edge indices above, so a flit that is early, late or separated by a gap is caught even when its value is right.

// File: rtl/cell_tx_pkg.sv
package cell_tx_pkg;

  typedef enum logic [2:0] {
    ST_FILL,
    ST_HDR0,
    ST_HDR1,
    ST_WAIT,
    ST_BURST,
    ST_HOLD
  } tx_state_e;

  typedef enum logic [1:0] {
    POS_NONE  = 2'b00,
    POS_FIRST = 2'b01,
    POS_MID   = 2'b10,
    POS_LAST  = 2'b11
  } cell_pos_e;

endpackage

// File: rtl/cell_tx_store.sv
module cell_tx_store #(
  parameter int W     = 8,
  parameter int AW    = 7,
  parameter int DEPTH = 128
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/cell_tx_backoff.sv
module cell_tx_backoff #(
  parameter int CNT_W  = 8,
  parameter int RELOAD = 127
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic en,
  output logic done
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                      cnt <= '0;
    else if (load)                cnt <= CNT_W'(RELOAD);
    else if (en && cnt != '0)     cnt <= cnt - CNT_W'(1);
  end

  assign done = (cnt == '0);

endmodule

// File: rtl/cell_session_tx.sv
module cell_session_tx
  import cell_tx_pkg::*;
#(
  parameter int FLIT_W     = 8,
  parameter int ADDR_W     = 5,
  parameter int CELL_FLITS = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FLIT_W-1:0] in_data,
  input  logic              in_valid,
  input  logic              in_last,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] dst_addr,
  input  logic [ADDR_W-1:0] src_addr,
  input  logic              ack,
  input  logic              nack,
  output logic [FLIT_W-1:0] out_flit,
  output logic              out_valid,
  output logic              out_eop
);

  localparam int PTR_W = (CELL_FLITS > 1) ? $clog2(CELL_FLITS) : 1;
  localparam int LEN_W = $clog2(CELL_FLITS + 1);
  localparam int DEPTH = 1 << PTR_W;
  localparam int PAD0  = FLIT_W - ADDR_W - 2;
  localparam int PAD1  = FLIT_W - ADDR_W;
  localparam logic [PTR_W-1:0] PTR_END = PTR_W'(CELL_FLITS - 1);

  tx_state_e         st;
  cell_pos_e         pos_q;
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [LEN_W-1:0]  cell_len, sent;
  logic [ADDR_W-1:0] dst_q, src_q;
  logic              in_msg;
  logic [FLIT_W-1:0] rdata;
  logic              we, closing, burst_end, bo_done, bo_load;
  logic [FLIT_W-1:0] hdr0, hdr1;

  assign in_ready  = (st == ST_FILL);
  assign we        = in_valid && in_ready;
  assign closing   = we && (in_last || wr_ptr == PTR_END);
  assign burst_end = (sent == cell_len - LEN_W'(1));
  assign bo_load   = (st == ST_WAIT) && !ack && nack;
  assign hdr0      = {{PAD0{1'b0}}, pos_q, dst_q};
  assign hdr1      = {{PAD1{1'b0}}, src_q};

  cell_tx_store #(
    .W     (FLIT_W),
    .AW    (PTR_W),
    .DEPTH (DEPTH)
  ) u_store (
    .clk   (clk),
    .we    (we),
    .waddr (wr_ptr),
    .wdata (in_data),
    .raddr (rd_ptr),
    .rdata (rdata)
  );

  cell_tx_backoff #(
    .CNT_W  (LEN_W),
    .RELOAD (CELL_FLITS - 1)
  ) u_backoff (
    .clk  (clk),
    .rst  (rst),
    .load (bo_load),
    .en   (st == ST_HOLD),
    .done (bo_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_FILL;
      pos_q     <= POS_NONE;
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      cell_len  <= '0;
      sent      <= '0;
      dst_q     <= '0;
      src_q     <= '0;
      in_msg    <= 1'b0;
      out_flit  <= '0;
      out_valid <= 1'b0;
      out_eop   <= 1'b0;
    end else begin
      case (st)
        ST_FILL: begin
          out_valid <= 1'b0;
          out_eop   <= 1'b0;
          if (we) begin
            wr_ptr <= wr_ptr + PTR_W'(1);
            if (closing) begin
              st       <= ST_HDR0;
              wr_ptr   <= '0;
              cell_len <= LEN_W'(wr_ptr) + LEN_W'(1);
              dst_q    <= dst_addr;
              src_q    <= src_addr;
              pos_q    <= in_last ? POS_LAST : (in_msg ? POS_MID : POS_FIRST);
            end
          end
        end
        ST_HDR0: begin
          out_flit  <= hdr0;
          out_valid <= 1'b1;
          out_eop   <= 1'b0;
          st        <= ST_HDR1;
        end
        ST_HDR1: begin
          out_flit  <= hdr1;
          out_valid <= 1'b1;
          rd_ptr    <= '0;
          st        <= ST_WAIT;
        end
        ST_WAIT: begin
          out_valid <= 1'b0;
          if (ack) begin
            st     <= ST_BURST;
            rd_ptr <= PTR_W'(1);
            sent   <= '0;
          end else if (nack) begin
            st <= ST_HOLD;
          end
        end
        ST_BURST: begin
          out_flit  <= rdata;
          out_valid <= 1'b1;
          out_eop   <= burst_end;
          rd_ptr    <= rd_ptr + PTR_W'(1);
          sent      <= sent + LEN_W'(1);
          if (burst_end) begin
            st     <= ST_FILL;
            in_msg <= (pos_q != POS_LAST);
          end
        end
        ST_HOLD: begin
          out_valid <= 1'b0;
          if (bo_done) st <= ST_HDR0;
        end
        default: st <= ST_FILL;
      endcase
    end
  end

  AST_EOP_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst) out_eop |-> out_valid) else $error("eop without valid"); // R7
  AST_IDLE_AFTER_EOP: assert property (@(posedge clk) disable iff (rst) out_eop |=> !out_valid) else $error("flit right after eop"); // R7
  AST_HDR_TWO_FLITS: assert property (@(posedge clk) disable iff (rst) (st == ST_HDR1) |=> (out_valid && !out_eop)) else $error("second control flit missing"); // R3
  AST_WAIT_SILENT: assert property (@(posedge clk) disable iff (rst) (st == ST_WAIT && !ack) |=> !out_valid) else $error("data before ack"); // R5
  AST_HOLD_SILENT: assert property (@(posedge clk) disable iff (rst) (st == ST_HOLD) |=> !out_valid) else $error("flit during backoff"); // R9
  AST_NO_WRITE_IN_BURST: assert property (@(posedge clk) disable iff (rst) (st == ST_BURST || st == ST_WAIT) |-> !in_ready) else $error("producer not stalled"); // R2

endmodule

// File: tb/cell_session_tx_test.sv
`timescale 1ns/1ps
module cell_session_tx_test;

  localparam int CELL = 4;

  typedef struct {
    logic [7:0] f;
    logic       e;
    int         k;
    string      r;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] in_data = '0;
  logic       in_valid = 1'b0, in_last = 1'b0;
  logic       in_ready;
  logic [4:0] dst_addr = '0, src_addr = '0;
  logic       ack = 1'b0, nack = 1'b0;
  logic [7:0] out_flit;
  logic       out_valid, out_eop;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int ctrl0_cyc = 0, ctrl1_cnt = 0, data0_cyc = 0, last_cyc = 0;
  bit mon_on = 1'b0, finished = 1'b0;
  exp_t q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cell_session_tx #(.FLIT_W(8), .ADDR_W(5), .CELL_FLITS(CELL)) uut (
    .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid), .in_last(in_last),
    .in_ready(in_ready), .dst_addr(dst_addr), .src_addr(src_addr), .ack(ack), .nack(nack),
    .out_flit(out_flit), .out_valid(out_valid), .out_eop(out_eop));

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] f, input logic e, input int k, input string r);
    exp_t it;
    it.f = f; it.e = e; it.k = k; it.r = r;
    q.push_back(it);
  endtask

  task automatic push_hdr(input logic [1:0] p, input logic [4:0] d, input logic [4:0] s);
    push({1'b0, p, d}, 1'b0, 0, "R3 R4 control flit 0");
    push({3'b000, s}, 1'b0, 1, "R3 control flit 1");
  endtask

  // monitor: pops expected items as the design emits flits
  always @(negedge clk) begin
    exp_t e;
    if (!rst && mon_on) begin
      if (out_eop && !out_valid) chk(1'b0, "R7", "eop without valid", 1, 0);
      if (out_valid) begin
        if (q.size() == 0) begin
          chk(1'b0, "R5", "unexpected flit", int'(out_flit), -1);
        end else begin
          e = q.pop_front();
          chk(out_flit == e.f, e.r, "flit value", int'(out_flit), int'(e.f));
          chk(out_eop == e.e, "R7", "eop flag", int'(out_eop), int'(e.e));
          if (e.k == 0) ctrl0_cyc = cyc;
          if (e.k == 1) ctrl1_cnt++;
          if (e.k == 2) data0_cyc = cyc;
          if (e.k >= 2) last_cyc = cyc;
        end
      end
    end
  end

  task automatic wait_hdr(input int c1);
    while (ctrl1_cnt == c1) @(negedge clk);
  endtask

  task automatic send_msg(input int nwords, input logic [4:0] d, input logic [4:0] s,
                          input int nack_cell, input int nack_n, input int base);
    int done_w;
    int cidx;
    done_w = 0;
    cidx = 0;
    while (done_w < nwords) begin
      int clen;
      bit lastc;
      logic [1:0] p;
      int f, e, c1;
      clen  = (nwords - done_w > CELL) ? CELL : nwords - done_w;
      lastc = (done_w + clen == nwords);
      p     = lastc ? 2'b11 : ((cidx == 0) ? 2'b01 : 2'b10);
      for (int i = 0; i < clen; i++) begin
        @(negedge clk);
        chk(in_ready == 1'b1, "R2", "ready while filling", int'(in_ready), 1);
        in_valid = 1'b1;
        in_data  = 8'(base + done_w + i);
        in_last  = lastc && (i == clen - 1);
        dst_addr = d;
        src_addr = s;
      end
      @(negedge clk);
      in_valid = 1'b0;
      in_last  = 1'b0;
      f = cyc;
      chk(in_ready == 1'b0, "R2", "stall after cell closes", int'(in_ready), 0);
      c1 = ctrl1_cnt;
      push_hdr(p, d, s);
      wait_hdr(c1);
      chk(ctrl0_cyc == f + 1, "R3", "control flit 0 timing", ctrl0_cyc, f + 1);
      repeat (3) @(negedge clk);
      chk(out_valid == 1'b0, "R5", "link idle before ack", int'(out_valid), 0);
      chk(in_ready == 1'b0, "R2", "stall while waiting", int'(in_ready), 0);
      if (cidx == nack_cell) begin
        for (int n = 0; n < nack_n; n++) begin
          @(negedge clk);
          nack = 1'b1;
          e = cyc + 1;
          c1 = ctrl1_cnt;
          push_hdr(p, d, s);
          @(negedge clk);
          nack = 1'b0;
          wait_hdr(c1);
          chk(ctrl0_cyc == e + CELL + 1, "R9", "retry timing", ctrl0_cyc, e + CELL + 1);
          repeat (2) @(negedge clk);
        end
      end
      @(negedge clk);
      for (int i = 0; i < clen; i++)
        push(8'(base + done_w + i), (i == clen - 1), (i == 0) ? 2 : 3, "R6 R8 data flit");
      ack = 1'b1;
      e = cyc + 1;
      @(negedge clk);
      ack = 1'b0;
      while (q.size() != 0) @(negedge clk);
      chk(data0_cyc == e + 1, "R6", "first data flit timing", data0_cyc, e + 1);
      chk(last_cyc == e + clen, "R8", "cell length on link", last_cyc - e, clen);
      done_w += clen;
      cidx++;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1", "valid after reset", int'(out_valid), 0);
    chk(out_eop == 1'b0, "R1", "eop after reset", int'(out_eop), 0);
    chk(in_ready == 1'b1, "R1", "ready after reset", int'(in_ready), 1);
    mon_on = 1'b1;
    send_msg(3, 5'h13, 5'h02, -1, 0, 8'h40);   // single short cell (R4 R8)
    send_msg(10, 5'h06, 5'h1A, 1, 1, 8'h80);   // first, middle with nack, short last (R4 R9)
    send_msg(4, 5'h1F, 5'h00, 0, 2, 8'hC0);    // exactly one cell, two nacks (R9)
    send_msg(8, 5'h0A, 5'h15, -1, 0, 8'h10);   // ends on cell boundary (R4)
    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R6", "expected queue drained", q.size(), 0);
    chk(in_ready == 1'b1, "R2", "ready after last cell", int'(in_ready), 1);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule